// File: doc/BRIEF.md
# Second-Operand Barrel Shifter

This block is a purely combinational shifter placed in front of an ALU's second input. It takes a data word, a shift kind, a shift distance and the present carry flag. It returns the transformed word and a carry-out. Flag-update logic downstream can use that carry-out in place of the ALU carry when the instruction is a logical one.

There are five shift kinds: logical left, logical right, arithmetic right, rotate right, and a one-place rotate that passes through the carry flag. Left shifts reuse the right-shift datapath by mirroring the word on the way in and out. That leaves a single logarithmic rotator, a fill mask and a carry tap. A distance of zero means "no shift": the word and the carry flag pass through untouched.

The block has no clock, so results are valid in the same cycle as the inputs. The distance port is one bit wider than log2 of the word width. It therefore covers every value from zero up to the full width. Distances above the word width are outside the block's contract.

Top module: `operand_shifter`

## Requirements
- R1: With kind code 0 (logical left) and a distance n from 1 to WIDTH, the result is the input moved up n places with zeros entering at bit 0. The carry-out is input bit WIDTH−n, so n = WIDTH gives a zero result and carry equal to bit 0.
- R2: With kind code 1 (logical right) and n from 1 to WIDTH, the result is the input moved down n places with zeros entering at the top. The carry-out is input bit n−1, so n = WIDTH gives zero with carry equal to the top bit.
- R3: With kind code 2 (arithmetic right) and n from 1 to WIDTH, the vacated top bits are copies of the input's top bit. The carry-out is input bit n−1, so n = WIDTH gives a word of sign copies with carry equal to the sign.
- R4: With kind code 3 (rotate right), bits leaving bit 0 re-enter at the top. The distance is taken modulo WIDTH. For a nonzero distance the carry-out equals the new top bit of the result, so n = WIDTH returns the input with carry equal to its top bit.
- R5: With kind code 4 (carry rotate), the result is the input moved down one place with the carry flag in the top bit. The carry-out is input bit 0, and the distance input has no effect.
- R6: For kind codes 0 to 3 with a distance of zero, the result equals the input and the carry-out equals the carry flag.
- R7: Kind codes 5, 6 and 7 pass the input and the carry flag through unchanged for every distance.
- R8: A logical left shift by 3 fed to an adder with a base value yields base plus eight times the input, modulo 2^WIDTH.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_i | input | WIDTH | Word to be shifted |
| kind_i | input | 3 | Shift kind code (0 lsl, 1 lsr, 2 asr, 3 ror, 4 carry rotate) |
| amt_i | input | $clog2(WIDTH)+1 | Shift distance, 0 to WIDTH |
| carry_i | input | 1 | Present carry flag |
| res_o | output | WIDTH | Shifted word |
| carry_o | output | 1 | Shifter carry-out |

## Verification
The bench builds the block at its default WIDTH of 32, which gives a 6-bit distance port. At that width every distance from 0 to 32 can be swept for all eight kind codes. Each sweep is run with both carry values and over patterns with a set sign bit, a clear sign bit, alternating bits and single set bits at either end. Sweeping every distance reaches the full-width edge cases of every kind. It also reaches the modulo wrap of the rotate and the pass-through of the spare kind codes, and it shows that the carry rotate ignores its distance.

// File: rtl/shf_pkg.sv
package shf_pkg;
  typedef enum logic [2:0] {
    SHF_LSL = 3'd0,
    SHF_LSR = 3'd1,
    SHF_ASR = 3'd2,
    SHF_ROR = 3'd3,
    SHF_RRX = 3'd4
  } shf_kind_e;
endpackage

// File: rtl/shf_bitrev.sv
module shf_bitrev #(
  parameter int W = 32
) (
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    assign q_o[i] = d_i[W-1-i];
  end
endmodule

// File: rtl/shf_rotr.sv
module shf_rotr #(
  parameter int W     = 32,
  parameter int LOG_W = $clog2(W)
) (
  input  logic [W-1:0]     d_i,
  input  logic [LOG_W-1:0] n_i,
  output logic [W-1:0]     q_o
);
  logic [W-1:0] stg [LOG_W+1];

  assign stg[0] = d_i;

  // stage k rotates by 2^k when distance bit k is set
  for (genvar k = 0; k < LOG_W; k++) begin : g_stage
    localparam int S = 1 << k;
    assign stg[k+1] = n_i[k] ? {stg[k][S-1:0], stg[k][W-1:S]} : stg[k];
  end

  assign q_o = stg[LOG_W];
endmodule

// File: rtl/shf_keep_mask.sv
module shf_keep_mask #(
  parameter int W     = 32,
  parameter int AMT_W = $clog2(W) + 1
) (
  input  logic [AMT_W-1:0] n_i,
  output logic [W-1:0]     keep_o
);
  localparam int SUM_W = AMT_W + 1;

  // bit i survives a right shift by n when i + n < W
  for (genvar i = 0; i < W; i++) begin : g_keep
    assign keep_o[i] = ({1'b0, n_i} + SUM_W'(i)) < SUM_W'(W);
  end
endmodule

// File: rtl/operand_shifter.sv
module operand_shifter
  import shf_pkg::*;
#(
  parameter int WIDTH = 32,
  localparam int LOG_W = $clog2(WIDTH),
  localparam int AMT_W = LOG_W + 1
) (
  input  logic [WIDTH-1:0] op_i,
  input  logic [2:0]       kind_i,
  input  logic [AMT_W-1:0] amt_i,
  input  logic             carry_i,
  output logic [WIDTH-1:0] res_o,
  output logic             carry_o
);
  logic             is_left;
  logic             amt_zero;
  logic [WIDTH-1:0] op_rev;
  logic [WIDTH-1:0] src;
  logic [WIDTH-1:0] rot;
  logic [WIDTH-1:0] keep;
  logic [WIDTH-1:0] lsr_val;
  logic [WIDTH-1:0] lsl_val;
  logic [WIDTH-1:0] sign_fill;

  assign is_left  = (kind_i == SHF_LSL);
  assign amt_zero = (amt_i == '0);

  shf_bitrev #(.W(WIDTH)) u_rev_in (
    .d_i (op_i),
    .q_o (op_rev)
  );

  // left shifts run through the right-shift path on a mirrored word
  assign src = is_left ? op_rev : op_i;

  shf_rotr #(.W(WIDTH), .LOG_W(LOG_W)) u_rotr (
    .d_i (src),
    .n_i (amt_i[LOG_W-1:0]),
    .q_o (rot)
  );

  shf_keep_mask #(.W(WIDTH), .AMT_W(AMT_W)) u_mask (
    .n_i    (amt_i),
    .keep_o (keep)
  );

  assign lsr_val   = rot & keep;
  assign sign_fill = ~keep & {WIDTH{src[WIDTH-1]}};

  shf_bitrev #(.W(WIDTH)) u_rev_out (
    .d_i (lsr_val),
    .q_o (lsl_val)
  );

  // the last bit shifted out always lands at rot[top]
  always_comb begin
    res_o   = op_i;
    carry_o = carry_i;
    unique case (kind_i)
      SHF_LSL: if (!amt_zero) begin
        res_o   = lsl_val;
        carry_o = rot[WIDTH-1];
      end
      SHF_LSR: if (!amt_zero) begin
        res_o   = lsr_val;
        carry_o = rot[WIDTH-1];
      end
      SHF_ASR: if (!amt_zero) begin
        res_o   = lsr_val | sign_fill;
        carry_o = rot[WIDTH-1];
      end
      SHF_ROR: if (!amt_zero) begin
        res_o   = rot;
        carry_o = rot[WIDTH-1];
      end
      SHF_RRX: begin
        res_o   = {carry_i, op_i[WIDTH-1:1]};
        carry_o = op_i[0];
      end
      default: ;
    endcase
  end

  always_comb begin
    if (kind_i < 3'd4 && amt_i == '0)
      AST_ZERO_PASS: assert (res_o == op_i && carry_o == carry_i) else $error("zero pass"); // R6
    if (kind_i == SHF_LSL && amt_i != '0)
      AST_LSL_LOW_ZERO: assert (res_o[0] == 1'b0) else $error("lsl fill"); // R1
    if (kind_i == SHF_LSR && amt_i != '0)
      AST_LSR_TOP_ZERO: assert (res_o[WIDTH-1] == 1'b0) else $error("lsr fill"); // R2
    if (kind_i == SHF_ASR)
      AST_ASR_SIGN: assert (res_o[WIDTH-1] == op_i[WIDTH-1]) else $error("asr sign"); // R3
    if (kind_i == SHF_ROR)
      AST_ROR_POP: assert ($countones(res_o) == $countones(op_i)) else $error("ror pop"); // R4
    if (kind_i == SHF_RRX)
      AST_RRX_POP: assert ($countones({carry_o, res_o}) == $countones({carry_i, op_i}))
        else $error("rrx pop"); // R5
    if (kind_i > 3'd4)
      AST_SPARE_PASS: assert (res_o == op_i && carry_o == carry_i) else $error("spare"); // R7
  end
endmodule

// File: tb/sim_operand_shifter.sv
`timescale 1ns/1ps
module sim_operand_shifter;
  localparam int W = 32;

  typedef struct {
    logic [W-1:0] res;
    logic         co;
    string        tag;
    logic         sum_chk;
    logic [W-1:0] base;
    logic [W-1:0] op;
  } item_t;

  logic         clk = 1'b0;
  logic         rst_ni = 1'b0;
  logic [W-1:0] op_i = '0;
  logic [2:0]   kind_i = '0;
  logic [5:0]   amt_i = '0;
  logic         carry_i = 1'b0;
  logic [W-1:0] res_o;
  logic         carry_o;

  int total = 0;
  int bad = 0;
  item_t sb_q[$];

  always #2.5 clk = ~clk;

  operand_shifter u0 (
    .op_i    (op_i),
    .kind_i  (kind_i),
    .amt_i   (amt_i),
    .carry_i (carry_i),
    .res_o   (res_o),
    .carry_o (carry_o)
  );

  function automatic logic [W:0] ref_model(logic [2:0] k, int n, logic [W-1:0] v, logic ci);
    logic [64:0]        tl;
    logic [W:0]         tr;
    logic signed [W:0]  ts;
    logic [W-1:0]       r;
    int                 m;
    case (k)
      3'd0: begin
        if (n == 0) return {ci, v};
        tl = {33'b0, v} << n;
        return {tl[W], tl[W-1:0]};
      end
      3'd1: begin
        if (n == 0) return {ci, v};
        tr = {v, 1'b0} >> n;
        return {tr[0], tr[W:1]};
      end
      3'd2: begin
        if (n == 0) return {ci, v};
        ts = $signed({v, 1'b0}) >>> n;
        return {ts[0], ts[W:1]};
      end
      3'd3: begin
        if (n == 0) return {ci, v};
        m = n % W;
        if (m == 0) return {v[W-1], v};
        r = (v >> m) | (v << (W - m));
        return {r[W-1], r};
      end
      3'd4: return {v[0], ci, v[W-1:1]};
      default: return {ci, v};
    endcase
  endfunction

  function automatic string tag_of(logic [2:0] k, int n);
    if (k < 3'd4 && n == 0) return "R6";
    case (k)
      3'd0: return "R1";
      3'd1: return "R2";
      3'd2: return "R3";
      3'd3: return "R4";
      3'd4: return "R5";
      default: return "R7";
    endcase
  endfunction

  task automatic drive(logic [2:0] k, int n, logic [W-1:0] v, logic ci, string tag, logic sc, logic [W-1:0] b);
    item_t it;
    logic [W:0] e;
    @(negedge clk);
    kind_i  = k;
    amt_i   = 6'(n);
    op_i    = v;
    carry_i = ci;
    e = ref_model(k, n, v, ci);
    it.res = e[W-1:0];
    it.co = e[W];
    it.tag = tag;
    it.sum_chk = sc;
    it.base = b;
    it.op = v;
    sb_q.push_back(it);
  endtask

  // monitor: inputs were set on the falling edge, results are settled here
  initial begin
    forever begin
      @(posedge clk);
      if (sb_q.size() > 0) begin
        item_t it;
        it = sb_q.pop_front();
        total++;
        if (res_o !== it.res || carry_o !== it.co) begin
          bad++;
          $display("FAIL %s kind=%0d amt=%0d op=%h: got res=%h co=%b exp res=%h co=%b",
                   it.tag, kind_i, amt_i, op_i, res_o, carry_o, it.res, it.co);
        end
        if (it.sum_chk) begin
          total++;
          if (it.base + res_o !== it.base + it.op * 8) begin
            bad++;
            $display("FAIL R8 sum: got %h exp %h", it.base + res_o, it.base + it.op * 8);
          end
        end
      end
    end
  end

  initial begin
    #200000;
    bad++;
    $display("FAIL watchdog: got hang exp finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [W-1:0] pats [6];
    pats[0] = 32'h8000_0001;
    pats[1] = 32'h7FFF_FFFE;
    pats[2] = 32'hA5A5_5A5A;
    pats[3] = 32'hFFFF_FFFF;
    pats[4] = 32'h0000_0000;
    pats[5] = 32'h1234_8765;
    repeat (3) @(posedge clk);
    rst_ni = 1'b1;
    drive(3'd0, 0, '0, 1'b0, "R6 reset", 1'b0, '0);
    for (int k = 0; k < 8; k++) begin
      for (int p = 0; p < 6; p++) begin
        for (int c = 0; c < 2; c++) begin
          for (int n = 0; n <= W; n++) begin
            drive(3'(k), n, pats[p], c[0], tag_of(3'(k), n), 1'b0, '0);
          end
        end
      end
    end
    drive(3'd0, 3, 32'h0000_0123, 1'b0, "R8", 1'b1, 32'h0000_1000);
    drive(3'd0, 3, 32'hF000_0011, 1'b1, "R8", 1'b1, 32'hFFFF_FF00);
    while (sb_q.size() > 0) @(posedge clk);
    @(negedge clk);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule